// File: doc/BRIEF.md
# HDLC Timeslot Access Mux

This block places an internal HDLC bit-stream engine on one chosen channel of a framed T1 or E1 line. It is bit-serial and works one line bit per clock. A line framer drives the frame position as a timeslot number, a bit number, an F-bit flag and a frame-parity flag. On the transmit side, the block replaces backplane bits with HDLC bits inside the tapped octet. On the receive side, it flags which raw line bits, taken ahead of the elastic buffer, belong to the HDLC receiver.

The tap is set by a control word with four fields: enable, payload select, rate and a 5-bit channel number. With payload select high, the tap is a payload channel. With payload select low, the tap is the facility data link of a T1 extended-superframe line, or timeslot 0 of an E1 line. The rate bit chooses between 64 kb/s, which uses all eight bits of the octet, and 56 kb/s, which skips the last bit of each octet. The control word is captured only on the first bit of a frame. A frame is therefore never half-substituted.

Top module: `hdlc_slot_mux`

## Requirements
- R1: In T1 mode with payload select 1, channel value 0..23 taps the timeslot of that number (0 = first channel after the F bit). Values 24..31 tap nothing.
- R2: In E1 mode with payload select 1, channel values 1..31 tap that timeslot. Value 0 taps nothing.
- R3: With payload select 0, the tap depends on the line. In E1 mode it is timeslot 0. In T1 mode without `esf_mode`, nothing is tapped.
- R4: With enable 0, `tx_out` equals `tx_in` and both strobes stay low.
- R5: In every cycle where `hdlc_tx_req` is 1, `tx_out` equals `hdlc_tx_bit`.
- R6: `hdlc_rx_valid` rises in exactly the cycles that carry HDLC bits, and `hdlc_rx_bit` then equals `rx_line`.
- R7: `bit_cnt` numbers the bits of an octet 0..7 in line order, with 7 the least significant bit. With rate 1 (64 kb/s) all eight bits are used. With rate 0 (56 kb/s), bit 7 of a tapped octet carries no strobe, and `tx_out` is forced to 1 there.
- R8: In T1 data-link mode, strobes occur only when `fbit` = 1, `frame_odd` = 1 and `esf_mode` = 1, for one bit per such frame.
- R9: The control inputs are sampled in the cycle where `frame_start` = 1. They govern that cycle and every cycle up to the next `frame_start`. Changes at any other time have no effect within the current frame.
- R10: After reset, before the first `frame_start`, the block behaves as disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_e1 | input | 1 | 1 = E1 framing, 0 = T1 framing |
| esf_mode | input | 1 | T1 extended-superframe framing |
| frame_start | input | 1 | First bit of a frame |
| frame_odd | input | 1 | Current frame carries a data-link F bit |
| fbit | input | 1 | Current bit is the T1 F bit |
| ts_cnt | input | 5 | Current timeslot number |
| bit_cnt | input | 3 | Current bit within the octet, 0 first |
| cfg_en | input | 1 | HDLC access enable |
| cfg_payload | input | 1 | 1 = payload channel, 0 = data link / timeslot 0 |
| cfg_rate64 | input | 1 | 1 = 64 kb/s, 0 = 56 kb/s |
| cfg_chan | input | 5 | Selected channel number |
| tx_in | input | 1 | Backplane transmit bit |
| hdlc_tx_bit | input | 1 | Bit offered by the HDLC transmitter |
| rx_line | input | 1 | Received line bit ahead of the elastic buffer |
| tx_out | output | 1 | Transmit bit toward the line |
| hdlc_tx_req | output | 1 | HDLC transmit bit consumed this cycle |
| hdlc_rx_bit | output | 1 | Bit for the HDLC receiver |
| hdlc_rx_valid | output | 1 | `hdlc_rx_bit` is an HDLC bit |

## Verification
Two events can fall in the same cycle: capture of a new control word, and an HDLC bit in the tapped position. This happens because `frame_start` marks the T1 F bit and E1 timeslot 0 bit 0, which are exactly the data-link and timeslot-0 taps. The bench provokes this by programming data-link and timeslot-0 routings on the first bit of the frame. It also rewrites the control inputs in the middle of each frame. The bench model applies a new word only from the `frame_start` cycle, so the first tapped bit must already follow it, and a mid-frame change must leave the rest of the frame untouched.

// File: rtl/hdlc_slot_mux.sv
module hdlc_slot_mux #(
  parameter int TS_W    = 5,
  parameter int BIT_W   = 3,
  parameter int T1_LAST = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_e1,
  input  logic             esf_mode,
  input  logic             frame_start,
  input  logic             frame_odd,
  input  logic             fbit,
  input  logic [TS_W-1:0]  ts_cnt,
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic             cfg_en,
  input  logic             cfg_payload,
  input  logic             cfg_rate64,
  input  logic [TS_W-1:0]  cfg_chan,
  input  logic             tx_in,
  input  logic             hdlc_tx_bit,
  input  logic             rx_line,
  output logic             tx_out,
  output logic             hdlc_tx_req,
  output logic             hdlc_rx_bit,
  output logic             hdlc_rx_valid
);

  localparam logic [BIT_W-1:0] LSB_POS = '1;

  logic            en_q, pay_q, r64_q;
  logic [TS_W-1:0] ch_q;

  // control word: live on the frame's first bit, held for the rest
  wire            act_en  = frame_start ? cfg_en      : en_q;
  wire            act_pay = frame_start ? cfg_payload : pay_q;
  wire            act_r64 = frame_start ? cfg_rate64  : r64_q;
  wire [TS_W-1:0] act_ch  = frame_start ? cfg_chan    : ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pay_q <= 1'b0;
      r64_q <= 1'b0;
      ch_q  <= '0;
    end else if (frame_start) begin
      en_q  <= cfg_en;
      pay_q <= cfg_payload;
      r64_q <= cfg_rate64;
      ch_q  <= cfg_chan;
    end
  end

  wire f_slot  = !is_e1 && fbit;
  wire ch_ok   = is_e1 ? (act_ch != '0) : (int'(act_ch) <= T1_LAST);
  wire pay_hit = act_pay && ch_ok && !f_slot && (ts_cnt == act_ch);
  wire ts0_hit = !act_pay && is_e1 && (ts_cnt == '0);
  wire slot    = act_en && (pay_hit || ts0_hit);
  wire dl_hit  = act_en && !act_pay && f_slot && esf_mode && frame_odd;
  wire drop    = !act_r64 && (bit_cnt == LSB_POS);
  wire use_bit = (slot && !drop) || dl_hit;

  assign hdlc_tx_req   = use_bit;
  assign hdlc_rx_valid = use_bit;
  assign hdlc_rx_bit   = rx_line;
  assign tx_out        = use_bit ? hdlc_tx_bit : (slot ? 1'b1 : tx_in);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en) |-> (tx_out == tx_in && !hdlc_tx_req && !hdlc_rx_valid)); // R4
  AST_TX_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_tx_req |-> (tx_out == hdlc_tx_bit)); // R5
  AST_STUFF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdlc_tx_req && tx_out != tx_in) |-> (tx_out && bit_cnt == LSB_POS && !act_r64)); // R7
  AST_LSB_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_r64 && bit_cnt == LSB_POS && !f_slot) |-> !hdlc_rx_valid); // R7
  AST_DL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hdlc_rx_valid && f_slot) |-> (frame_odd && esf_mode && !act_pay)); // R8
  AST_T1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hdlc_rx_valid && !is_e1 && !fbit) |-> (int'(ts_cnt) <= T1_LAST)); // R1
  AST_E1_TS0: assert property (@(posedge clk) disable iff (!rst_n)
    (hdlc_rx_valid && is_e1 && ts_cnt == '0) |-> !act_pay); // R2
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start) |=> ($stable(en_q) && $stable(ch_q) && $stable(pay_q))); // R9

endmodule

// File: tb/tb_hdlc_slot_mux.sv
module tb_hdlc_slot_mux;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic is_e1 = 0, esf_mode = 0, frame_start = 0, frame_odd = 0, fbit = 0;
  logic [4:0] ts_cnt = '0, cfg_chan = '0;
  logic [2:0] bit_cnt = '0;
  logic cfg_en = 0, cfg_payload = 0, cfg_rate64 = 0;
  logic tx_in = 0, hdlc_tx_bit = 0, rx_line = 0;
  logic tx_out, hdlc_tx_req, hdlc_rx_bit, hdlc_rx_valid;

  int n_chk = 0, n_bad = 0;
  logic m_en = 0, m_pay = 0, m_r64 = 0;
  logic [4:0] m_ch = '0;

  always #(CLK_P/2) clk = ~clk;

  hdlc_slot_mux dut (.*);

  task automatic chk(input logic ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at ts=%0d bit=%0d", req, act, exp, ts_cnt, bit_cnt);
    end
  endtask

  function automatic logic slot_exp();
    logic hit;
    if (!m_en) return 1'b0;
    if (m_pay) hit = (is_e1 ? m_ch != 0 : m_ch <= 23) && !(!is_e1 && fbit) && ts_cnt == m_ch;
    else hit = is_e1 && ts_cnt == 0;
    return hit;
  endfunction

  function automatic logic use_exp();
    logic dl;
    dl = m_en && !m_pay && !is_e1 && fbit && esf_mode && frame_odd;
    return dl || (slot_exp() && (m_r64 || bit_cnt != 3'd7));
  endfunction

  task automatic rand_cfg();
    cfg_en = ($urandom % 5) != 0;
    cfg_payload = ($urandom % 3) != 0;
    cfg_rate64 = $urandom % 2;
    cfg_chan = 5'($urandom % 32);
  endtask

  task automatic set_cfg(input logic en, input logic pay, input logic r64, input int ch);
    cfg_en = en; cfg_payload = pay; cfg_rate64 = r64; cfg_chan = 5'(ch);
  endtask

  task automatic check_bit(input bit dirty);
    logic u, s, et;
    string tag;
    u = use_exp();
    s = slot_exp();
    et = u ? hdlc_tx_bit : (s ? 1'b1 : tx_in);
    if (dirty) tag = "R9";
    else if (!m_en) tag = "R4";
    else if (!is_e1 && fbit) tag = "R8";
    else if (!m_pay) tag = "R3";
    else if (s && !u) tag = "R7";
    else if (is_e1) tag = "R2";
    else tag = "R1";
    chk(hdlc_tx_req == u, tag, hdlc_tx_req, u);
    chk(hdlc_rx_valid == u, tag, hdlc_rx_valid, u);
    chk(tx_out == et, u ? "R5" : tag, tx_out, et);
    if (u) chk(hdlc_rx_bit == rx_line, "R6", hdlc_rx_bit, rx_line);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    // R10: reset and idle before first frame start
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 3) rst_n = 1'b1;
      set_cfg(1, 0, 1, 0);
      is_e1 = 1; ts_cnt = '0; tx_in = $urandom; hdlc_tx_bit = ~tx_in;
      #1;
      chk(tx_out == tx_in, "R10", tx_out, tx_in);
      chk(!hdlc_rx_valid, "R10", hdlc_rx_valid, 1'b0);
    end
    for (int f = 0; f < 160; f++) begin
      int len;
      is_e1 = (f >= 80);
      esf_mode = (f < 60);
      frame_odd = f[0];
      len = is_e1 ? 256 : 193;
      case (f)
        0:  set_cfg(1, 1, 1, 0);
        1:  set_cfg(1, 1, 0, 23);
        2:  set_cfg(1, 1, 1, 24);
        3:  set_cfg(0, 1, 1, 5);
        4, 5: set_cfg(1, 0, 1, 7);
        60: set_cfg(1, 0, 1, 3);
        80: set_cfg(1, 1, 1, 0);
        81: set_cfg(1, 1, 0, 31);
        82: set_cfg(1, 0, 0, 9);
        83: set_cfg(1, 0, 1, 9);
        default: if ($urandom % 4 == 0) rand_cfg();
      endcase
      for (int b = 0; b < len; b++) begin
        @(negedge clk);
        frame_start = (b == 0);
        if (is_e1) begin
          fbit = 0; ts_cnt = 5'(b / 8); bit_cnt = 3'(b % 8);
        end else begin
          fbit = (b == 0);
          ts_cnt = (b == 0) ? 5'd0 : 5'((b - 1) / 8);
          bit_cnt = (b == 0) ? 3'd0 : 3'((b - 1) % 8);
        end
        if (b == len / 2) rand_cfg();
        if (frame_start) begin
          m_en = cfg_en; m_pay = cfg_payload; m_r64 = cfg_rate64; m_ch = cfg_chan;
        end
        tx_in = $urandom; hdlc_tx_bit = $urandom; rx_line = $urandom;
        #1;
        check_bit(b >= len / 2 && (cfg_en != m_en || cfg_chan != m_ch || cfg_payload != m_pay));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule